// File: doc/BRIEF.md
# Page-Wide Hamming ECC Engine

This block sits beside the data path between a host and a NAND flash device and watches each data beat as it passes. Over the whole data area of a page it accumulates one single-error-correcting, double-error-detecting code. The code is a set of positional parity bits: each bit of the location address of every set data bit is folded into a true parity word, and its complement into an inverted parity word. On a program operation the host reads the two 16-bit parity words once the last data beat has gone by, and writes them to the spare area as four check bytes.

On a read, the host passes the page data through the block and then, right after it, the four stored check bytes. Once the last check beat has been taken, the block compares the stored words with the freshly computed ones. It reports one of four outcomes: clean, a single correctable data bit with its word and bit position, a single flipped bit inside the check bytes, or an uncorrectable pattern. An erased page (all ones, check bytes included) always yields the uncorrectable flag with an all-ones location, and software reads that pair as "erased, no error". A soft clear discards everything gathered so far, and the beat counter wraps by itself at the end of each full page (data plus spare).

Top module: `page_ecc`

## Requirements
- R1: After `rst`, `par_o`, `npar_o` and `loc_o` read zero and `rec_err`, `mul_err` and `chk_err` are low.
- R2: For each set data bit at location A = word_index*16 + bit_index (bit_index 0..7 on an 8-bit bus, 0..15 on a 16-bit bus), bit k of `par_o` toggles when A[k]=1 and bit k of `npar_o` toggles when A[k]=0. Both words are valid in the cycle after the last data beat.
- R3: `page_mode` 0, 1, 2, 3 selects 512, 1024, 2048, 4096 data bytes and 528, 1056, 2112, 4224 bytes per full page. With `wide`=1 each beat carries two bytes, so both counts are halved in beats.
- R4: The check beats immediately follow the data. On an 8-bit bus they are four bytes, in this order: `par_o` low byte, `par_o` high byte, `npar_o` low byte, `npar_o` high byte. On a 16-bit bus they are two beats: the full parity word, then the full inverted word.
- R5: If the stored check value equals the computed one, all three flags are low and `loc_o` is zero after the last check beat.
- R6: If the syndrome (stored XOR computed, per word) has every true bit the complement of its inverted bit, `rec_err`=1, `mul_err`=0 and `chk_err`=0. `loc_o` then holds the failing location: bits [3:0] give the bit, bits [15:4] give the word.
- R7: If exactly one of the 32 syndrome bits is set, `rec_err`=1, `chk_err`=1 and `mul_err`=0.
- R8: Any other non-zero syndrome gives `rec_err`=1, `mul_err`=1 and `chk_err`=0, with `loc_o` equal to the true-parity syndrome. A fully erased page therefore shows `loc_o`=16'hFFFF.
- R9: After the last beat of a full page the beat counter returns to zero and both parity words clear, so the next page starts fresh.
- R10: A cycle with `soft_clr` high clears the parity words, the flags, the location and the beat counter, so earlier beats are excluded from the next result.
- R11: A cycle with `strobe` low changes no output, whatever `din` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_clr | input | 1 | Clears accumulators, flags and beat counter |
| strobe | input | 1 | A data or check beat is on `din` this cycle |
| wide | input | 1 | 1: 16-bit bus, 0: 8-bit bus (uses `din[7:0]`) |
| page_mode | input | 2 | Page length select (see R3) |
| din | input | 16 | Beat value |
| par_o | output | 16 | Accumulated true parity word |
| npar_o | output | 16 | Accumulated inverted parity word |
| loc_o | output | 16 | Error location: [15:4] word, [3:0] bit |
| rec_err | output | 1 | Some error was found |
| mul_err | output | 1 | Uncorrectable (or erased) pattern |
| chk_err | output | 1 | Single flipped bit inside the check bytes |

## Verification
The bound checker watches, on every cycle, the relations that must always hold between outputs. It checks that a soft clear leaves everything at zero, that an idle cycle freezes every output, and that the uncorrectable and check-byte flags are never both set. It also checks that the uncorrectable flag never appears without the error flag, that a clean result carries a zero location, and that the beat counter stays inside the selected page length. The actual parity values, the syndrome classification, the decoded location, the byte order of the check beats and the page lengths of the four modes depend on the page contents. Only the bench's scenarios show these, with its behavioural model compared on every clock: clean, single-bit, check-byte, double-bit and erased pages, both bus widths and all page lengths.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    localparam int BUS_W      = 16;
    localparam int NARROW_W   = 8;
    localparam int BIT_W      = 4;
    localparam int WORD_W     = 12;
    localparam int LOC_W      = BIT_W + WORD_W;
    localparam int IDX_W      = 13;
    localparam int BASE_DATA  = 512;
    localparam int BASE_PAGE  = 528;
    localparam int CHK_BYTES  = 4;
    localparam int CHK_W      = CHK_BYTES * 8;

    typedef logic [LOC_W-1:0] loc_t;
    typedef logic [IDX_W-1:0] idx_t;

    typedef enum logic [1:0] {
        PG_528  = 2'd0,
        PG_1056 = 2'd1,
        PG_2112 = 2'd2,
        PG_4224 = 2'd3
    } page_mode_e;

    typedef enum logic [1:0] {
        PH_DATA  = 2'd0,
        PH_CHECK = 2'd1,
        PH_SPARE = 2'd2
    } phase_e;

    typedef struct packed {
        loc_t p;
        loc_t np;
    } par_pair_t;

    typedef struct packed {
        logic rec;
        logic mul;
        logic chk;
    } ecc_flags_t;

    // Beats in the data area for a mode and bus width
    function automatic idx_t data_beats(page_mode_e m, logic wide);
        idx_t v;
        v = idx_t'(BASE_DATA) << m;
        return wide ? (v >> 1) : v;
    endfunction

    // Beats in a full page (data plus spare)
    function automatic idx_t page_beats(page_mode_e m, logic wide);
        idx_t v;
        v = idx_t'(BASE_PAGE) << m;
        return wide ? (v >> 1) : v;
    endfunction

    function automatic idx_t check_beats(logic wide);
        return wide ? idx_t'(CHK_BYTES / 2) : idx_t'(CHK_BYTES);
    endfunction

    // Parity contribution of one beat at a given word index
    function automatic par_pair_t beat_parity(logic [BUS_W-1:0] d, logic wide,
                                              logic [WORD_W-1:0] word);
        par_pair_t r;
        loc_t      acc;
        logic      odd;
        acc = '0;
        odd = 1'b0;
        for (int b = 0; b < BUS_W; b++) begin
            if ((b < NARROW_W || wide) && d[b]) begin
                acc = acc ^ {word, BIT_W'(b)};
                odd = ~odd;
            end
        end
        r.p  = acc;
        r.np = acc ^ {LOC_W{odd}};
        return r;
    endfunction

    // Sort a syndrome into the reported outcome
    function automatic ecc_flags_t classify(loc_t sp, loc_t sn);
        ecc_flags_t f;
        int         n;
        f = '0;
        n = $countones({sp, sn});
        if (n == 0) begin
            f = '0;
        end else if ((sp ^ sn) == {LOC_W{1'b1}}) begin
            f.rec = 1'b1;
        end else if (n == 1) begin
            f.rec = 1'b1;
            f.chk = 1'b1;
        end else begin
            f.rec = 1'b1;
            f.mul = 1'b1;
        end
        return f;
    endfunction

endpackage

// File: rtl/ecc_position.sv
module ecc_position
    import ecc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       stb,
    input  page_mode_e mode,
    input  logic       wide,
    output idx_t       idx,
    output phase_e     phase,
    output logic [1:0] slot,
    output logic       last_chk,
    output logic       wrap,
    output idx_t       page_len
);

    idx_t dlen;
    idx_t clen;

    assign dlen     = data_beats(mode, wide);
    assign clen     = check_beats(wide);
    assign page_len = page_beats(mode, wide);

    always_comb begin
        if (idx < dlen)
            phase = PH_DATA;
        else if (idx < dlen + clen)
            phase = PH_CHECK;
        else
            phase = PH_SPARE;
    end

    assign slot     = 2'(idx - dlen);
    assign last_chk = (idx == dlen + clen - 1'b1);
    assign wrap     = stb && (idx == page_len - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clr)
            idx <= '0;
        else if (stb)
            idx <= wrap ? '0 : idx + 1'b1;
    end

endmodule

// File: rtl/ecc_accum.sv
module ecc_accum
    import ecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wrap,
    input  logic              take,
    input  logic              wide,
    input  logic [BUS_W-1:0]  din,
    input  logic [WORD_W-1:0] word,
    output par_pair_t         acc
);

    par_pair_t step;

    assign step = beat_parity(din, wide, word);

    always_ff @(posedge clk) begin
        if (rst || clr || wrap)
            acc <= '0;
        else if (take)
            acc <= acc ^ step;
    end

endmodule

// File: rtl/ecc_syndrome.sv
module ecc_syndrome
    import ecc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             take,
    input  logic             last,
    input  logic [1:0]       slot,
    input  logic             wide,
    input  logic [BUS_W-1:0] din,
    input  par_pair_t        calc,
    output ecc_flags_t       flags,
    output loc_t             loc
);

    logic [CHK_W-1:0] store_q;
    logic [CHK_W-1:0] store_d;
    loc_t             syn_p;
    loc_t             syn_n;

    // Place the incoming beat at its byte or half-word slot
    always_comb begin
        store_d = store_q;
        if (wide)
            store_d[{slot[0], 4'b0000} +: BUS_W] = din;
        else
            store_d[{slot, 3'b000} +: NARROW_W] = din[NARROW_W-1:0];
    end

    assign syn_p = calc.p  ^ store_d[LOC_W-1:0];
    assign syn_n = calc.np ^ store_d[CHK_W-1:LOC_W];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            store_q <= '0;
            flags   <= '0;
            loc     <= '0;
        end else if (take) begin
            store_q <= store_d;
            if (last) begin
                flags <= classify(syn_p, syn_n);
                loc   <= syn_p;
            end
        end
    end

endmodule

// File: rtl/page_ecc.sv
module page_ecc
    import ecc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        soft_clr,
    input  logic        strobe,
    input  logic        wide,
    input  logic [1:0]  page_mode,
    input  logic [15:0] din,
    output logic [15:0] par_o,
    output logic [15:0] npar_o,
    output logic [15:0] loc_o,
    output logic        rec_err,
    output logic        mul_err,
    output logic        chk_err
);

    idx_t       pos_idx;
    idx_t       pos_len;
    phase_e     pos_phase;
    logic [1:0] pos_slot;
    logic       pos_last;
    logic       pos_wrap;
    par_pair_t  acc;
    ecc_flags_t flags;
    loc_t       loc;
    logic       take_data;
    logic       take_chk;

    ecc_position u_pos (
        .clk      (clk),
        .rst      (rst),
        .clr      (soft_clr),
        .stb      (strobe),
        .mode     (page_mode_e'(page_mode)),
        .wide     (wide),
        .idx      (pos_idx),
        .phase    (pos_phase),
        .slot     (pos_slot),
        .last_chk (pos_last),
        .wrap     (pos_wrap),
        .page_len (pos_len)
    );

    assign take_data = strobe && !soft_clr && (pos_phase == PH_DATA);
    assign take_chk  = strobe && !soft_clr && (pos_phase == PH_CHECK);

    ecc_accum u_acc (
        .clk  (clk),
        .rst  (rst),
        .clr  (soft_clr),
        .wrap (pos_wrap),
        .take (take_data),
        .wide (wide),
        .din  (din),
        .word (pos_idx[WORD_W-1:0]),
        .acc  (acc)
    );

    ecc_syndrome u_syn (
        .clk   (clk),
        .rst   (rst),
        .clr   (soft_clr),
        .take  (take_chk),
        .last  (pos_last),
        .slot  (pos_slot),
        .wide  (wide),
        .din   (din),
        .calc  (acc),
        .flags (flags),
        .loc   (loc)
    );

    assign par_o   = acc.p;
    assign npar_o  = acc.np;
    assign loc_o   = loc;
    assign rec_err = flags.rec;
    assign mul_err = flags.mul;
    assign chk_err = flags.chk;

endmodule

// File: rtl/page_ecc_chk.sv
module page_ecc_chk
    import ecc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        soft_clr,
    input logic        strobe,
    input logic [15:0] par_o,
    input logic [15:0] npar_o,
    input logic [15:0] loc_o,
    input logic        rec_err,
    input logic        mul_err,
    input logic        chk_err,
    input idx_t        idx,
    input idx_t        page_len
);

    // R10
    clr_wipes_chk: assert property (@(posedge clk) disable iff (rst)
        soft_clr |=> (par_o == '0 && npar_o == '0 && loc_o == '0 &&
                      !rec_err && !mul_err && !chk_err));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!strobe && !soft_clr) |=> ($stable(par_o) && $stable(npar_o) &&
                                    $stable(loc_o) && $stable({rec_err, mul_err, chk_err})));

    // R8
    mul_has_rec_chk: assert property (@(posedge clk) disable iff (rst)
        mul_err |-> rec_err);

    // R7
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mul_err && chk_err));

    // R5
    clean_loc_chk: assert property (@(posedge clk) disable iff (rst)
        !rec_err |-> (loc_o == '0));

    // R9
    idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
        idx < page_len);

endmodule

bind page_ecc page_ecc_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .soft_clr (soft_clr),
    .strobe   (strobe),
    .par_o    (par_o),
    .npar_o   (npar_o),
    .loc_o    (loc_o),
    .rec_err  (rec_err),
    .mul_err  (mul_err),
    .chk_err  (chk_err),
    .idx      (pos_idx),
    .page_len (pos_len)
);

// File: tb/page_ecc_tb_top.sv
module page_ecc_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        soft_clr;
    logic        strobe;
    logic        wide;
    logic [1:0]  page_mode;
    logic [15:0] din;
    logic [15:0] par_o, npar_o, loc_o;
    logic        rec_err, mul_err, chk_err;

    int total = 0;
    int bad   = 0;

    // behavioural reference state
    int          m_idx;
    logic [15:0] m_p, m_np, m_loc;
    logic [2:0]  m_flags;      // {rec, mul, chk}
    logic [7:0]  m_cq[$];

    always #5 clk = ~clk;

    page_ecc dut_i (
        .clk(clk), .rst(rst), .soft_clr(soft_clr), .strobe(strobe),
        .wide(wide), .page_mode(page_mode), .din(din),
        .par_o(par_o), .npar_o(npar_o), .loc_o(loc_o),
        .rec_err(rec_err), .mul_err(mul_err), .chk_err(chk_err)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int dbeats();
        return (512 << page_mode) / (wide ? 2 : 1);
    endfunction
    function automatic int pbeats();
        return (528 << page_mode) / (wide ? 2 : 1);
    endfunction
    function automatic int cbeats();
        return wide ? 2 : 4;
    endfunction

    // Parity of a whole data area, straight from the location rule
    function automatic logic [31:0] golden(logic [15:0] q[$], logic w);
        logic [15:0] p = 16'h0, np = 16'h0, a;
        for (int i = 0; i < q.size(); i++)
            for (int b = 0; b < (w ? 16 : 8); b++)
                if (q[i][b]) begin
                    a  = 16'(i * 16 + b);
                    p  = p ^ a;
                    np = np ^ ~a;
                end
        return {np, p};
    endfunction

    task automatic model_reset();
        m_idx = 0; m_p = '0; m_np = '0; m_loc = '0; m_flags = '0;
        m_cq.delete();
    endtask

    task automatic model_step(bit s, bit c, logic [15:0] d);
        logic [15:0] sp, sn, a;
        int n;
        if (c) begin
            model_reset();
        end else if (s) begin
            if (m_idx < dbeats()) begin
                for (int b = 0; b < (wide ? 16 : 8); b++)
                    if (d[b]) begin
                        a    = 16'(m_idx * 16 + b);
                        m_p  = m_p ^ a;
                        m_np = m_np ^ ~a;
                    end
            end else if (m_idx < dbeats() + cbeats()) begin
                m_cq.push_back(d[7:0]);
                if (wide) m_cq.push_back(d[15:8]);
                if (m_idx == dbeats() + cbeats() - 1) begin
                    sp = m_p  ^ {m_cq[1], m_cq[0]};
                    sn = m_np ^ {m_cq[3], m_cq[2]};
                    n  = $countones({sp, sn});
                    if (n == 0)                  m_flags = 3'b000;
                    else if ((sp ^ sn) == 16'hFFFF) m_flags = 3'b100;
                    else if (n == 1)             m_flags = 3'b101;
                    else                         m_flags = 3'b110;
                    m_loc = sp;
                    m_cq.delete();
                end
            end
            m_idx++;
            if (m_idx == pbeats()) begin
                m_idx = 0; m_p = '0; m_np = '0; m_cq.delete();
            end
        end
    endtask

    task automatic compare_all();
        check("R2", "model par", par_o, m_p);
        check("R2", "model npar", npar_o, m_np);
        check("R6", "model loc", loc_o, m_loc);
        check("R8", "model flags", {rec_err, mul_err, chk_err}, m_flags);
    endtask

    // one clock: compare, drive, advance model, wait for next falling edge
    task automatic step(bit s, bit c, logic [15:0] d);
        compare_all();
        strobe = s; soft_clr = c; din = d;
        model_step(s, c, d);
        @(negedge clk);
    endtask

    task automatic send_data(logic [15:0] q[$], int idle_every);
        logic [15:0] hold;
        for (int i = 0; i < q.size(); i++) begin
            if (idle_every > 0 && (i % idle_every) == idle_every - 1) begin
                hold = par_o;
                step(1'b0, 1'b0, 16'($urandom));
                check("R11", "par across idle beat", par_o, hold);
            end
            step(1'b1, 1'b0, q[i]);
        end
    endtask

    task automatic send_check(logic [31:0] g);
        if (wide) begin
            step(1'b1, 1'b0, g[15:0]);
            step(1'b1, 1'b0, g[31:16]);
        end else begin
            step(1'b1, 1'b0, {8'h00, g[7:0]});
            step(1'b1, 1'b0, {8'h00, g[15:8]});
            step(1'b1, 1'b0, {8'h00, g[23:16]});
            step(1'b1, 1'b0, {8'h00, g[31:24]});
        end
    endtask

    task automatic send_spare();
        for (int i = 0; i < pbeats() - dbeats() - cbeats(); i++)
            step(1'b1, 1'b0, 16'hFFFF);
    endtask

    function automatic void fill(ref logic [15:0] q[$], input int n, input logic w);
        q.delete();
        for (int i = 0; i < n; i++)
            q.push_back(w ? 16'($urandom) : {8'h00, 8'($urandom)});
    endfunction

    initial begin : wdog
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [15:0] q[$];
        logic [15:0] e[$];
        logic [31:0] g;
        rst = 1'b1; soft_clr = 1'b0; strobe = 1'b0; wide = 1'b0;
        page_mode = 2'd0; din = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        check("R1", "par after reset", par_o, 0);
        check("R1", "npar after reset", npar_o, 0);
        check("R1", "loc after reset", loc_o, 0);
        check("R1", "flags after reset", {rec_err, mul_err, chk_err}, 0);

        // clean 512-byte page
        fill(q, 512, 1'b0);
        g = golden(q, 1'b0);
        send_data(q, 0);
        check("R2", "par after data", par_o, g[15:0]);
        check("R2", "npar after data", npar_o, g[31:16]);
        send_check(g);
        check("R5", "clean flags", {rec_err, mul_err, chk_err}, 3'b000);
        check("R4", "clean loc with ordered check bytes", loc_o, 0);
        send_spare();
        check("R9", "par after wrap", par_o, 0);
        check("R9", "npar after wrap", npar_o, 0);

        // single data bit error
        e = q; e[300] = e[300] ^ 16'h0020;
        send_data(e, 0);
        send_check(g);
        check("R6", "single flags", {rec_err, mul_err, chk_err}, 3'b100);
        check("R6", "single loc", loc_o, 300 * 16 + 5);
        send_spare();

        // one bit flipped in the stored check bytes
        send_data(q, 0);
        send_check(g ^ 32'h0400_0000);
        check("R7", "check-byte flags", {rec_err, mul_err, chk_err}, 3'b101);
        send_spare();

        // two data bit errors
        e = q; e[10] = e[10] ^ 16'h0001; e[20] = e[20] ^ 16'h0008;
        send_data(e, 0);
        send_check(g);
        check("R8", "double flags", {rec_err, mul_err, chk_err}, 3'b110);
        send_spare();

        // erased page
        e.delete();
        for (int i = 0; i < 512; i++) e.push_back(16'h00FF);
        send_data(e, 0);
        send_check(32'hFFFF_FFFF);
        check("R8", "erased flags", {rec_err, mul_err, chk_err}, 3'b110);
        check("R8", "erased loc", loc_o, 16'hFFFF);
        send_spare();

        // 16-bit bus, 1024-byte data area
        wide = 1'b1; page_mode = 2'd1;
        fill(q, 512, 1'b1);
        g = golden(q, 1'b1);
        e = q; e[400] = e[400] ^ 16'h2000;
        send_data(e, 0);
        send_check(g);
        check("R6", "wide single flags", {rec_err, mul_err, chk_err}, 3'b100);
        check("R4", "wide check beats give loc", loc_o, 400 * 16 + 13);
        send_spare();

        // 2048-byte data area, clean, with idle beats
        wide = 1'b0; page_mode = 2'd2;
        fill(q, 2048, 1'b0);
        g = golden(q, 1'b0);
        send_data(q, 97);
        send_check(g);
        check("R3", "mode 2 clean flags", {rec_err, mul_err, chk_err}, 3'b000);
        send_spare();

        // 4096-byte data area with an error near the end
        page_mode = 2'd3;
        fill(q, 4096, 1'b0);
        g = golden(q, 1'b0);
        e = q; e[4000] = e[4000] ^ 16'h0080;
        send_data(e, 0);
        send_check(g);
        check("R3", "mode 3 single flags", {rec_err, mul_err, chk_err}, 3'b100);
        check("R3", "mode 3 loc", loc_o, 4000 * 16 + 7);
        send_spare();

        // soft clear in the middle of a page
        page_mode = 2'd0;
        fill(q, 100, 1'b0);
        send_data(q, 0);
        step(1'b0, 1'b1, 16'h0000);
        check("R10", "par after clear", par_o, 0);
        check("R10", "npar after clear", npar_o, 0);
        fill(q, 512, 1'b0);
        g = golden(q, 1'b0);
        send_data(q, 0);
        send_check(g);
        check("R10", "page after clear is clean", {rec_err, mul_err, chk_err}, 3'b000);
        send_spare();

        compare_all();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule